// File: doc/BRIEF.md
# Bipolar Associative Pattern Memory

This block is a small recurrent associative memory. It holds a square array of signed integer weights that connect every neuron to every other neuron. It supports two main jobs. A store command folds one bipolar pattern into the array, so that the pattern later acts as an attractor. A recall command loads a probe that may be noisy and lets the neurons settle to the nearest stored attractor. A third command wipes the array. Each pattern bit stands for one neuron: 1 means +1 and 0 means -1.

During recall the block updates one neuron per evaluation, and a 16-bit maximal-length LFSR picks that neuron. The net input of the chosen neuron is built serially, one add or subtract per clock, with no multiplier. The neuron then takes the sign of the sum, and a sum of zero counts as positive. Recall ends in one of two ways:
- **Convergence:** every neuron has been evaluated since the last state flip.
- **Timeout:** a programmable cycle budget runs out first.

A command is issued with a one-cycle `start`. The block raises `busy` while a recall is running and pulses `done` for one cycle when any command finishes.

Top module: `assoc_mem`

## Requirements
- R1: After reset, `busy`, `done`, `err_full` and `timeout` are 0, `state_out` is all zeros, and every weight is zero.
- R2: Store (`op` = 2'b00) adds +1 to weight (i,j) when pattern bits i and j are equal, and -1 when they differ, for every i≠j. It completes with `done` in the cycle after the command is accepted.
- R3: Clear (`op` = 2'b10 or 2'b11) sets every weight to zero, resets the count of stored patterns, and clears `err_full`.
- R4: Recall (`op` = 2'b01) first copies `pattern` into the neuron states. It then updates one neuron at a time: the neuron becomes 1 when the sum over j≠i of w(i,j)·y(j) is ≥ 0, and 0 otherwise. With all weights zero, any probe therefore recalls all ones.
- R5: With one stored pattern, a probe that differs from it in one bit recalls the stored pattern, and the bitwise inverse of the stored pattern recalls that inverse.
- R6: With two mutually orthogonal stored patterns (equal in exactly N/2 bits), recalling either one returns it unchanged.
- R7: A store issued when P_MAX patterns are already held is refused. `err_full` is raised with `done`, and the weights are left unchanged.
- R8: When the recall cycle count has reached `max_cycles` at the end of an evaluation and the state has not converged, recall ends with `done` and `timeout` = 1. `state_out` then shows the current state.
- R9: Convergence is declared only after every neuron index has been evaluated without a flip since the last flip. A converged recall reports `timeout` = 0 and lasts at least N·(N+2) busy cycles.
- R10: A `start` is ignored while `busy` or `done` is high. It neither changes the weights nor starts a command.
- R11: `busy` is high from the cycle after a recall is accepted until it finishes. `done` is high for exactly one cycle and never at the same time as `busy`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Command strobe, accepted only when idle |
| op | input | 2 | 00 store, 01 recall, 1x clear |
| pattern | input | N | Pattern to store or probe to recall (1 = +1, 0 = -1) |
| max_cycles | input | CW | Recall cycle budget |
| busy | output | 1 | Recall in progress |
| done | output | 1 | One-cycle completion pulse |
| state_out | output | N | Neuron states (recovered pattern) |
| err_full | output | 1 | Last store was refused because the memory was full |
| timeout | output | 1 | Last recall ended on the cycle budget |

## Verification
The bench checks two cases where a new command strobe arrives in the same cycle as another activity:
- **During a recall:** a clear command is raised one cycle after the recall starts, while `busy` is high.
- **In the completion cycle:** a clear command is raised again in the exact cycle where `done` is high.

In both cases the bench judges the result from the ports. It checks that neither `busy` nor `done` follows the ignored strobe. It then recalls a corrupted probe, which must still return the stored pattern rather than the all-ones result that a cleared array would give.

// File: rtl/amem_pkg.sv
package amem_pkg;

  typedef enum logic [2:0] {
    S_IDLE,
    S_PICK,
    S_ACC,
    S_UPD,
    S_FIN
  } amem_state_e;

  localparam logic [1:0] OP_STORE  = 2'b00;
  localparam logic [1:0] OP_RECALL = 2'b01;

  localparam int unsigned LFSR_W = 16;
  localparam logic [LFSR_W-1:0] LFSR_TAPS = 16'hB400;

endpackage

// File: rtl/amem_lfsr.sv
module amem_lfsr #(
  parameter int unsigned W = 16,
  parameter logic [W-1:0] TAPS = 16'hB400,
  parameter logic [W-1:0] SEED = 16'hACE1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         adv,
  output logic [W-1:0] value
);

  logic [W-1:0] q_q;
  logic [W-1:0] q_d;

  always_comb begin
    q_d = q_q >> 1;
    if (q_q[0]) begin
      q_d = q_d ^ TAPS;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q_q <= SEED;
    end else if (adv) begin
      q_q <= q_d;
    end
  end

  assign value = q_q;

endmodule

// File: rtl/amem_weights.sv
module amem_weights #(
  parameter int unsigned N  = 8,
  parameter int unsigned WW = 3
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   clr,
  input  logic                   wr,
  input  logic [N-1:0]           pat,
  input  logic [$clog2(N)-1:0]   rd_row,
  input  logic [$clog2(N)-1:0]   rd_col,
  output logic signed [WW-1:0]   rd_val
);

  localparam logic signed [WW-1:0] WMAX = {1'b0, {(WW-1){1'b1}}};
  localparam logic signed [WW-1:0] WMIN = {1'b1, {(WW-1){1'b0}}};

  logic signed [WW-1:0] wmat [N][N];

  for (genvar gi = 0; gi < N; gi++) begin : g_row
    for (genvar gj = 0; gj < N; gj++) begin : g_col
      if (gi == gj) begin : g_diag
        assign wmat[gi][gj] = '0;
      end else begin : g_cell
        logic signed [WW-1:0] w_q;
        logic signed [WW-1:0] w_d;
        logic                 agree;

        always_comb begin
          agree = (pat[gi] == pat[gj]);
          w_d   = w_q;
          if (clr) begin
            w_d = '0;
          end else if (wr) begin
            if (agree && (w_q != WMAX)) begin
              w_d = w_q + WW'(1);
            end else if (!agree && (w_q != WMIN)) begin
              w_d = w_q - WW'(1);
            end
          end
        end

        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) begin
            w_q <= '0;
          end else if (clr || wr) begin
            w_q <= w_d;
          end
        end

        assign wmat[gi][gj] = w_q;
      end
    end
  end

  assign rd_val = wmat[rd_row][rd_col];

endmodule

// File: rtl/amem_netacc.sv
module amem_netacc #(
  parameter int unsigned WW = 3,
  parameter int unsigned AW = 7
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 clr,
  input  logic                 en,
  input  logic signed [WW-1:0] w,
  input  logic                 yj,
  output logic signed [AW-1:0] acc
);

  logic signed [AW-1:0] acc_q;
  logic signed [AW-1:0] acc_d;
  logic signed [AW-1:0] w_ext;

  assign w_ext = {{(AW-WW){w[WW-1]}}, w};

  always_comb begin
    acc_d = acc_q;
    if (clr) begin
      acc_d = '0;
    end else if (en) begin
      acc_d = yj ? (acc_q + w_ext) : (acc_q - w_ext);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q <= '0;
    end else if (clr || en) begin
      acc_q <= acc_d;
    end
  end

  assign acc = acc_q;

endmodule

// File: rtl/assoc_mem.sv
module assoc_mem
  import amem_pkg::*;
#(
  parameter int unsigned N     = 8,
  parameter int unsigned P_MAX = 2,
  parameter int unsigned CW    = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [1:0]    op,
  input  logic [N-1:0]  pattern,
  input  logic [CW-1:0] max_cycles,
  output logic          busy,
  output logic          done,
  output logic [N-1:0]  state_out,
  output logic          err_full,
  output logic          timeout
);

  localparam int unsigned IW   = $clog2(N);
  localparam int unsigned WW   = $clog2(P_MAX) + 2;
  localparam int unsigned AW   = WW + $clog2(N) + 1;
  localparam int unsigned CNTW = $clog2(P_MAX + 1);
  localparam logic [IW-1:0]     LAST_J = IW'(N - 1);
  localparam logic [CNTW-1:0]   FULL   = CNTW'(P_MAX);
  localparam logic [LFSR_W-1:0] NMOD   = LFSR_W'(N);

  amem_state_e st_q, st_d;
  logic [N-1:0]    y_q, y_d;
  logic [N-1:0]    seen_q, seen_d;
  logic [IW-1:0]   idx_q, idx_d;
  logic [IW-1:0]   j_q, j_d;
  logic [CW-1:0]   cyc_q, cyc_d;
  logic [CNTW-1:0] cnt_q, cnt_d;
  logic            err_q, err_d;
  logic            tmo_q, tmo_d;

  logic                 w_wr, w_clr;
  logic                 acc_clr, acc_en;
  logic                 lfsr_adv;
  logic [LFSR_W-1:0]    lfsr_val;
  logic [LFSR_W-1:0]    pick_full;
  logic signed [WW-1:0] w_rd;
  logic signed [AW-1:0] acc;
  logic                 new_bit;
  logic                 flip;
  logic [N-1:0]         hit;
  logic [N-1:0]         seen_upd;
  logic [CW-1:0]        cyc_inc;

  amem_lfsr #(
    .W    (LFSR_W),
    .TAPS (LFSR_TAPS),
    .SEED (16'hACE1)
  ) u_lfsr (
    .clk   (clk),
    .rst_n (rst_n),
    .adv   (lfsr_adv),
    .value (lfsr_val)
  );

  amem_weights #(
    .N  (N),
    .WW (WW)
  ) u_weights (
    .clk    (clk),
    .rst_n  (rst_n),
    .clr    (w_clr),
    .wr     (w_wr),
    .pat    (pattern),
    .rd_row (idx_q),
    .rd_col (j_q),
    .rd_val (w_rd)
  );

  amem_netacc #(
    .WW (WW),
    .AW (AW)
  ) u_acc (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (acc_clr),
    .en    (acc_en),
    .w     (w_rd),
    .yj    (y_q[j_q]),
    .acc   (acc)
  );

  assign pick_full = lfsr_val % NMOD;
  assign new_bit   = ~acc[AW-1];
  assign flip      = (new_bit != y_q[idx_q]);
  assign hit       = N'(1) << idx_q;
  assign seen_upd  = seen_q | hit;
  assign cyc_inc   = (cyc_q == '1) ? cyc_q : (cyc_q + CW'(1));

  always_comb begin
    st_d     = st_q;
    y_d      = y_q;
    seen_d   = seen_q;
    idx_d    = idx_q;
    j_d      = j_q;
    cyc_d    = cyc_q;
    cnt_d    = cnt_q;
    err_d    = err_q;
    tmo_d    = tmo_q;
    w_wr     = 1'b0;
    w_clr    = 1'b0;
    acc_clr  = 1'b0;
    acc_en   = 1'b0;
    lfsr_adv = 1'b0;

    case (st_q)
      S_IDLE: begin
        if (start) begin
          err_d = 1'b0;
          tmo_d = 1'b0;
          if (op[1]) begin
            w_clr = 1'b1;
            cnt_d = '0;
            st_d  = S_FIN;
          end else if (op == OP_RECALL) begin
            y_d    = pattern;
            seen_d = '0;
            cyc_d  = '0;
            st_d   = S_PICK;
          end else if (cnt_q == FULL) begin
            err_d = 1'b1;
            st_d  = S_FIN;
          end else begin
            w_wr  = 1'b1;
            cnt_d = cnt_q + CNTW'(1);
            st_d  = S_FIN;
          end
        end
      end

      S_PICK: begin
        lfsr_adv = 1'b1;
        acc_clr  = 1'b1;
        idx_d    = pick_full[IW-1:0];
        j_d      = '0;
        cyc_d    = cyc_inc;
        st_d     = S_ACC;
      end

      S_ACC: begin
        acc_en = (j_q != idx_q);
        j_d    = j_q + IW'(1);
        cyc_d  = cyc_inc;
        if (j_q == LAST_J) begin
          st_d = S_UPD;
        end
      end

      S_UPD: begin
        y_d[idx_q] = new_bit;
        seen_d     = flip ? '0 : seen_upd;
        cyc_d      = cyc_inc;
        if (!flip && (seen_upd == '1)) begin
          st_d = S_FIN;
        end else if (cyc_q >= max_cycles) begin
          tmo_d = 1'b1;
          st_d  = S_FIN;
        end else begin
          st_d = S_PICK;
        end
      end

      S_FIN: begin
        st_d = S_IDLE;
      end

      default: begin
        st_d = S_IDLE;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= S_IDLE;
      y_q    <= '0;
      seen_q <= '0;
      idx_q  <= '0;
      j_q    <= '0;
      cyc_q  <= '0;
      cnt_q  <= '0;
      err_q  <= 1'b0;
      tmo_q  <= 1'b0;
    end else begin
      st_q   <= st_d;
      y_q    <= y_d;
      seen_q <= seen_d;
      idx_q  <= idx_d;
      j_q    <= j_d;
      cyc_q  <= cyc_d;
      cnt_q  <= cnt_d;
      err_q  <= err_d;
      tmo_q  <= tmo_d;
    end
  end

  assign busy      = (st_q == S_PICK) || (st_q == S_ACC) || (st_q == S_UPD);
  assign done      = (st_q == S_FIN);
  assign state_out = y_q;
  assign err_full  = err_q;
  assign timeout   = tmo_q;

endmodule

// File: rtl/assoc_mem_chk.sv
module assoc_mem_chk #(
  parameter int unsigned N = 8
) (
  input logic         clk,
  input logic         rst_n,
  input logic         start,
  input logic         busy,
  input logic         done,
  input logic [N-1:0] state_out,
  input logic         err_full,
  input logic         timeout
);

  p_done_single_r11: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  p_busy_done_excl_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !(busy && done));

  p_one_flip_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(busy) && busy) |-> ($countones(state_out ^ $past(state_out)) <= 1));

  p_state_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(state_out) |-> ($past(busy) || $past(start)));

  p_busy_ends_done_r10: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> (busy || done));

  p_timeout_at_end_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(timeout) |-> done);

  p_refuse_at_end_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(err_full) |-> done);

endmodule

bind assoc_mem assoc_mem_chk #(.N(N)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .start     (start),
  .busy      (busy),
  .done      (done),
  .state_out (state_out),
  .err_full  (err_full),
  .timeout   (timeout)
);

// File: tb/sim_assoc_mem.sv
module sim_assoc_mem;

  localparam int N = 8;
  localparam logic [1:0] OPS = 2'b00;
  localparam logic [1:0] OPR = 2'b01;
  localparam logic [1:0] OPC = 2'b10;
  localparam logic [7:0] PA  = 8'hF0;
  localparam logic [7:0] PB  = 8'hCC;

  logic          clk;
  logic          rst_n;
  logic          start;
  logic [1:0]    op;
  logic [N-1:0]  pattern;
  logic [15:0]   max_c;
  logic          busy;
  logic          done;
  logic [N-1:0]  state_out;
  logic          err_full;
  logic          timeout;

  int n_chk = 0;
  int n_bad = 0;

  assoc_mem u0 (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (start),
    .op         (op),
    .pattern    (pattern),
    .max_cycles (max_c),
    .busy       (busy),
    .done       (done),
    .state_out  (state_out),
    .err_full   (err_full),
    .timeout    (timeout)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic run_cmd(input logic [1:0] o, input logic [7:0] p, input logic [15:0] mc,
                         output int bcnt, output bit first_busy);
    @(negedge clk);
    start = 1'b1; op = o; pattern = p; max_c = mc;
    @(negedge clk);
    start = 1'b0;
    first_busy = busy;
    bcnt = 0;
    while (!done) begin
      if (busy) bcnt++;
      @(negedge clk);
    end
  endtask

  task automatic t_reset();
    check(!busy && !done, "R1 busy/done", {busy, done}, 0);
    check(state_out == '0, "R1 state", state_out, 0);
    check(!err_full && !timeout, "R1 flags", {err_full, timeout}, 0);
  endtask

  task automatic t_zero_weights(input string req);
    int b; bit fb;
    run_cmd(OPR, 8'hA5, 16'hFFFF, b, fb);
    check(state_out == 8'hFF, {req, " R4 zero weights give all ones"}, state_out, 8'hFF);
    check(!timeout, "R9 no timeout", timeout, 0);
  endtask

  task automatic t_store_one();
    int b; bit fb;
    run_cmd(OPS, PA, 16'hFFFF, b, fb);
    check(!fb && done, "R2 R11 store done next cycle", {fb, done}, 1);
    check(!err_full, "R2 store accepted", err_full, 0);
  endtask

  task automatic t_recall_single();
    int b; bit fb;
    run_cmd(OPR, PA ^ 8'h08, 16'hFFFF, b, fb);
    check(fb, "R11 busy during recall", fb, 1);
    check(state_out == PA, "R5 R2 one-bit probe", state_out, PA);
    run_cmd(OPR, ~PA, 16'hFFFF, b, fb);
    check(state_out == ~PA, "R5 inverse probe", state_out, ~PA);
  endtask

  task automatic t_ignore_start();
    int b; bit fb;
    @(negedge clk);
    start = 1'b1; op = OPR; pattern = PA ^ 8'h40; max_c = 16'hFFFF;
    @(negedge clk);
    check(busy, "R11 busy after accept", busy, 1);
    op = OPC;
    @(negedge clk);
    start = 1'b0;
    while (!done) @(negedge clk);
    check(state_out == PA, "R10 recall unaffected", state_out, PA);
    start = 1'b1; op = OPC;
    @(negedge clk);
    start = 1'b0;
    check(!done && !busy, "R10 start in done cycle ignored", {busy, done}, 0);
    run_cmd(OPR, PA ^ 8'h01, 16'hFFFF, b, fb);
    check(state_out == PA, "R10 weights kept", state_out, PA);
  endtask

  task automatic t_converge_len();
    int b; bit fb;
    run_cmd(OPR, PA, 16'hFFFF, b, fb);
    check(state_out == PA, "R9 stable probe", state_out, PA);
    check(b >= N * (N + 2), "R9 every neuron evaluated", b, N * (N + 2));
    check(!timeout, "R9 timeout low", timeout, 0);
  endtask

  task automatic t_timeout();
    int b; bit fb;
    run_cmd(OPR, PA ^ 8'h04, 16'd1, b, fb);
    check(timeout, "R8 timeout set", timeout, 1);
    check(state_out == PA || state_out == (PA ^ 8'h04), "R8 current state", state_out, PA);
  endtask

  task automatic t_clear();
    int b; bit fb;
    run_cmd(OPC, 8'h00, 16'hFFFF, b, fb);
    t_zero_weights("R3");
  endtask

  task automatic t_two_patterns();
    int b; bit fb;
    run_cmd(OPS, PA, 16'hFFFF, b, fb);
    run_cmd(OPS, PB, 16'hFFFF, b, fb);
    check(!err_full, "R6 second store accepted", err_full, 0);
    run_cmd(OPR, PA, 16'hFFFF, b, fb);
    check(state_out == PA, "R6 first pattern", state_out, PA);
    run_cmd(OPR, PB, 16'hFFFF, b, fb);
    check(state_out == PB, "R6 second pattern", state_out, PB);
    run_cmd(OPS, 8'h3C, 16'hFFFF, b, fb);
    check(err_full, "R7 full store refused", err_full, 1);
    run_cmd(OPC, 8'h00, 16'hFFFF, b, fb);
    check(!err_full, "R3 clear drops error", err_full, 0);
  endtask

  task automatic t_refused_unchanged();
    int b; bit fb;
    run_cmd(OPS, PA, 16'hFFFF, b, fb);
    run_cmd(OPS, PA, 16'hFFFF, b, fb);
    run_cmd(OPS, PA ^ 8'h07, 16'hFFFF, b, fb);
    check(err_full, "R7 error flag", err_full, 1);
    run_cmd(OPR, PA ^ 8'h07, 16'hFFFF, b, fb);
    check(state_out == PA, "R7 weights unchanged", state_out, PA);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_bad++;
    $display("FAIL R11 watchdog actual=hung expected=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0; start = 1'b0; op = 2'b00; pattern = '0; max_c = 16'hFFFF;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_zero_weights("R1");
    t_store_one();
    t_recall_single();
    t_ignore_start();
    t_converge_len();
    t_timeout();
    t_clear();
    t_two_patterns();
    t_refused_unchanged();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule